// File: doc/BRIEF.md
# Interrupt Redirection Entry Controller

This block holds the 64-bit routing entry of a single interrupt input and converts activity on that input into delivery requests. A host reads and writes the entry as two 32-bit words through a small register port. The asynchronous input pin is synchronized, its polarity is applied, and it is treated either as an edge source or as a level source. Delivery can be masked.

Once a trigger is recognized, the block raises a send request. The request carries the vector, the delivery mode, the destination mode and the destination. It stays raised until the consumer answers with accept. Until then it reports delivery as pending, and a retry answer leaves the request raised. For level sources, an accepted message sets a remote-pending flag that blocks further requests. Only an end-of-interrupt notice carrying the entry's vector clears that flag. Edge sources are re-armed only after acceptance.

Top module: `irq_redir_entry`

## Requirements
- R1: After reset the low word (address 0) reads 0x0001_0000, with only mask bit 16 set. The high word (address 1) reads 0, and send_req is 0.
- R2: A write to address 0 sets the following fields, and a read returns them one cycle after reg_rd_en: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger [15] and mask [16]. A write to address 1 sets the destination, which reads back at [31:24]. All other bits read 0.
- R3: Delivery status (low bit 12) and remote-pending (low bit 14) are read-only, and host writes leave them unchanged.
- R4: With polarity 1 the pin is active low, so a high-to-low pin transition is an edge trigger and a low-to-high transition is not.
- R5: In edge mode (trigger 0) with mask 0, an inactive-to-active transition raises send_req within 6 cycles. The request carries the entry's vector, delivery mode and destination mode.
- R6: In physical mode (destination mode 0), send_dest is {4'b0, destination[3:0]}. In logical mode (destination mode 1), send_dest is the full 8-bit destination.
- R7: While mask is 1, edges are discarded without being kept pending, so unmasking later issues nothing. An active level raises no request and leaves remote-pending at 0.
- R8: An edge that arrives while a request is pending is ignored. After acceptance, the next edge is recognized.
- R9: Delivery status reads 1 from the issue of a request until it is accepted. send_req and its fields hold steady through retry answers and drop in the cycle after send_accept.
- R10: In level mode (trigger 1), a request is issued only while the pin is active, mask is 0, remote-pending is 0 and no request is pending. Acceptance sets remote-pending.
- R11: An eoi_valid pulse whose eoi_vector equals the entry's vector clears remote-pending in a level entry. A pulse with a different vector does not. If the level is still active, a new request follows.
- R12: Setting mask after a level message was accepted leaves remote-pending at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 1 | Asynchronous interrupt input |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 1 | Word select: 0 low, 1 high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd_en |
| send_req | output | 1 | Delivery request |
| send_vector | output | 8 | Vector of the request |
| send_dlv_mode | output | 3 | Delivery mode of the request |
| send_dest_logical | output | 1 | Destination mode of the request |
| send_dest | output | 8 | Resolved destination |
| send_accept | input | 1 | Consumer accepted the request |
| send_retry | input | 1 | Consumer refused, retry |
| eoi_valid | input | 1 | End-of-interrupt notice |
| eoi_vector | input | 8 | Vector of the notice |

## Verification
The hardest situation to reach is a second trigger arriving while a message is still waiting for the consumer's answer. An edge during that window must be lost. A level must not issue twice. The bench holds the request through runs of retry answers of random length and toggles the pin in the middle of them. Only then does it accept. It then checks that the ignored edge leaves no request behind and that a level issues again only after an end-of-interrupt notice with the matching vector.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int WORD_W    = 32;
  localparam int VEC_W     = 8;
  localparam int DMODE_W   = 3;
  localparam int DEST_W    = 8;
  localparam int PHYS_ID_W = 4;
  localparam int SYNC_STAGES = 2;

  // low-word bit positions
  localparam int B_DMODE   = 8;
  localparam int B_DESTMOD = 11;
  localparam int B_DLVS    = 12;
  localparam int B_POL     = 13;
  localparam int B_RIRR    = 14;
  localparam int B_TRIG    = 15;
  localparam int B_MASK    = 16;
  // high-word destination lsb
  localparam int B_DEST    = WORD_W - DEST_W;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic               mask;
    logic               trig_level;
    logic               pol_low;
    logic               dest_logical;
    logic [DMODE_W-1:0] dmode;
    logic [VEC_W-1:0]   vec;
  } entry_cfg_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic pin_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], pin_async};
  end

  assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_redir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              dlvs,
  input  logic              rirr,
  output entry_cfg_t        cfg,
  output logic [WORD_W-1:0] rdata
);
  entry_cfg_t        cfg_q;
  logic [WORD_W-1:0] low_word, high_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      cfg_q.mask <= 1'b1;
    end else if (wr_en) begin
      if (!addr) begin
        cfg_q.vec          <= wdata[VEC_W-1:0];
        cfg_q.dmode        <= wdata[B_DMODE +: DMODE_W];
        cfg_q.dest_logical <= wdata[B_DESTMOD];
        cfg_q.pol_low      <= wdata[B_POL];
        cfg_q.trig_level   <= wdata[B_TRIG];
        cfg_q.mask         <= wdata[B_MASK];
      end else begin
        cfg_q.dest         <= wdata[B_DEST +: DEST_W];
      end
    end
  end

  always_comb begin
    low_word                     = '0;
    low_word[VEC_W-1:0]          = cfg_q.vec;
    low_word[B_DMODE +: DMODE_W] = cfg_q.dmode;
    low_word[B_DESTMOD]          = cfg_q.dest_logical;
    low_word[B_DLVS]             = dlvs;
    low_word[B_POL]              = cfg_q.pol_low;
    low_word[B_RIRR]             = rirr;
    low_word[B_TRIG]             = cfg_q.trig_level;
    low_word[B_MASK]             = cfg_q.mask;
    high_word                    = '0;
    high_word[B_DEST +: DEST_W]  = cfg_q.dest;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= addr ? high_word : low_word;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/irq_delivery.sv
module irq_delivery
  import irq_redir_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_s,
  input  entry_cfg_t         cfg,
  input  logic               accept,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vector,
  output logic               req,
  output logic [VEC_W-1:0]   req_vec,
  output logic [DMODE_W-1:0] req_dmode,
  output logic               req_logical,
  output logic [DEST_W-1:0]  req_dest,
  output logic               rirr
);
  logic active, active_q, edge_hit, lvl_hit, launch;
  logic pend_q, lvl_q, rirr_q, acc_lvl, eoi_hit;
  logic [DEST_W-1:0] dest_res;

  assign active   = pin_s ^ cfg.pol_low;
  assign edge_hit = active & ~active_q & ~cfg.trig_level;
  assign lvl_hit  = active & cfg.trig_level & ~rirr_q;
  assign launch   = ~pend_q & ~cfg.mask & (edge_hit | lvl_hit);
  assign acc_lvl  = pend_q & accept & lvl_q;
  assign eoi_hit  = eoi_valid & (eoi_vector == cfg.vec) & cfg.trig_level;
  assign dest_res = cfg.dest_logical ? cfg.dest
                                     : {{(DEST_W-PHYS_ID_W){1'b0}}, cfg.dest[PHYS_ID_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      lvl_q       <= 1'b0;
      req_vec     <= '0;
      req_dmode   <= '0;
      req_logical <= 1'b0;
      req_dest    <= '0;
    end else if (launch) begin
      pend_q      <= 1'b1;
      lvl_q       <= cfg.trig_level;
      req_vec     <= cfg.vec;
      req_dmode   <= cfg.dmode;
      req_logical <= cfg.dest_logical;
      req_dest    <= dest_res;
    end else if (pend_q && accept) begin
      pend_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rirr_q <= 1'b0;
    else if (acc_lvl) rirr_q <= 1'b1;
    else if (eoi_hit) rirr_q <= 1'b0;
  end

  assign req  = pend_q;
  assign rirr = rirr_q;
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_pin,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic               reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               send_req,
  output logic [VEC_W-1:0]   send_vector,
  output logic [DMODE_W-1:0] send_dlv_mode,
  output logic               send_dest_logical,
  output logic [DEST_W-1:0]  send_dest,
  input  logic               send_accept,
  input  logic               send_retry,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vector
);
  entry_cfg_t cfg;
  logic       pin_s, rirr;
  logic       retry_unused;

  assign retry_unused = send_retry; // a retry simply keeps the request raised

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(irq_pin), .pin_sync(pin_s)
  );

  irq_entry_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .dlvs(send_req), .rirr(rirr),
    .cfg(cfg), .rdata(reg_rdata)
  );

  irq_delivery u_dlv (
    .clk(clk), .rst(rst), .pin_s(pin_s), .cfg(cfg), .accept(send_accept),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .req(send_req), .req_vec(send_vector), .req_dmode(send_dlv_mode),
    .req_logical(send_dest_logical), .req_dest(send_dest), .rirr(rirr)
  );
endmodule

// File: rtl/irq_redir_entry_chk.sv
module irq_redir_entry_chk
  import irq_redir_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             send_req,
  input logic             send_accept,
  input logic             send_retry,
  input logic [VEC_W-1:0] send_vector,
  input logic [DEST_W-1:0] send_dest,
  input logic             mask,
  input logic             trig,
  input logic             rirr,
  input logic [VEC_W-1:0] vec,
  input logic             eoi_valid,
  input logic [VEC_W-1:0] eoi_vector
);
  a_r9_held_on_retry: assert property (@(posedge clk) disable iff (rst)
    send_req && send_retry && !send_accept |=> send_req);

  a_r9_drop_on_accept: assert property (@(posedge clk) disable iff (rst)
    send_req && send_accept |=> !send_req);

  a_r9_fields_stable: assert property (@(posedge clk) disable iff (rst)
    send_req && !send_accept |=> $stable(send_vector) && $stable(send_dest));

  a_r7_masked_no_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(send_req) |-> !$past(mask));

  a_r10_no_launch_with_rirr: assert property (@(posedge clk) disable iff (rst)
    $rose(send_req) |-> !($past(rirr) && $past(trig)));

  a_r10_rirr_set_on_accept: assert property (@(posedge clk) disable iff (rst)
    send_req && send_accept && trig && $stable(trig) |=> rirr);

  a_r11_eoi_clears: assert property (@(posedge clk) disable iff (rst)
    eoi_valid && eoi_vector == vec && trig && rirr && !send_req |=> !rirr);
endmodule

bind irq_redir_entry irq_redir_entry_chk u_chk (
  .clk(clk), .rst(rst), .send_req(send_req), .send_accept(send_accept),
  .send_retry(send_retry), .send_vector(send_vector), .send_dest(send_dest),
  .mask(cfg.mask), .trig(cfg.trig_level), .rirr(rirr), .vec(cfg.vec),
  .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
);

// File: tb/irq_redir_entry_tb.sv
module irq_redir_entry_tb;
  logic clk = 0, rst = 1, irq_pin = 0;
  logic reg_wr_en = 0, reg_rd_en = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic send_req, send_dest_logical;
  logic [7:0] send_vector, send_dest;
  logic [2:0] send_dlv_mode;
  logic send_accept = 0, send_retry = 0, eoi_valid = 0;
  logic [7:0] eoi_vector = 0;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_redir_entry u_dut (.*);

  function automatic logic [31:0] low_w(input logic [7:0] v, input logic [2:0] m,
      input logic dm, input logic dl, input logic pl, input logic rr,
      input logic tr, input logic mk);
    return {15'b0, mk, tr, rr, pl, dl, dm, m, v};
  endfunction

  function automatic logic [31:0] low_fields(input logic [31:0] w);
    return w & 32'h0001_AFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1; reg_addr = a;
    @(negedge clk); reg_rd_en = 0; d = reg_rdata;
  endtask

  task automatic wait_req(input int n, output bit got);
    got = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (send_req) begin got = 1; break; end
    end
  endtask

  task automatic accept1;
    @(negedge clk); send_accept = 1;
    @(negedge clk); send_accept = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1; eoi_vector = v;
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic set_pin(input logic p);
    @(negedge clk); irq_pin = p;
  endtask

  initial begin
    logic [31:0] d, r;
    bit got;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, d); chk(d == 32'h0001_0000, "R1 low word", d, 32'h0001_0000);
    rd(1, d); chk(d == 0, "R1 high word", d, 0);
    chk(send_req == 0, "R1 send_req", send_req, 0);

    // R2 R3 random readback, masked so nothing triggers
    for (int i = 0; i < 20; i++) begin
      r = $urandom | 32'h0001_0000;
      wr(0, r); rd(0, d);
      chk(d == low_fields(r), "R2 R3 low readback", d, low_fields(r));
      r = $urandom;
      wr(1, r); rd(1, d);
      chk(d == {r[31:24], 24'b0}, "R2 high readback", d, {r[31:24], 24'b0});
    end

    // R5 R6 physical edge
    wr(1, 32'hA500_0000);
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wait_req(6, got); chk(!got, "R5 no request without edge", got, 0);
    set_pin(1); wait_req(6, got);
    chk(got, "R5 edge request", got, 1);
    chk(send_vector == 8'h3C, "R5 vector", send_vector, 8'h3C);
    chk(send_dlv_mode == 3'd5, "R5 delivery mode", send_dlv_mode, 5);
    chk(send_dest_logical == 0, "R5 dest mode", send_dest_logical, 0);
    chk(send_dest == 8'h05, "R6 physical dest", send_dest, 8'h05);
    rd(0, d); chk(d[12] == 1, "R9 status pending", d[12], 1);
    // R3 write attempts to set read-only bits
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0) & ~32'h1000);
    rd(0, d); chk(d[12] == 1 && d[14] == 0, "R3 read-only bits", d, 32'h1000);
    // R9 retries hold the request
    @(negedge clk); send_retry = 1;
    repeat (3) begin
      @(negedge clk); chk(send_req && send_vector == 8'h3C, "R9 held on retry", send_req, 1);
    end
    send_retry = 0;
    accept1; chk(send_req == 0, "R9 drop after accept", send_req, 1'b0);
    rd(0, d); chk(d[12] == 0, "R9 status idle", d[12], 0);

    // R6 logical, R8 re-arm
    wr(0, low_w(8'h3C, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    set_pin(0); repeat (4) @(negedge clk);
    set_pin(1); wait_req(6, got);
    chk(got, "R8 edge after accept", got, 1);
    chk(send_dest == 8'hA5, "R6 logical dest", send_dest, 8'hA5);
    set_pin(0); repeat (4) @(negedge clk);
    set_pin(1); repeat (4) @(negedge clk);
    accept1; wait_req(8, got);
    chk(!got, "R8 edge while pending ignored", got, 0);

    // R4 active-low
    wr(0, low_w(8'h3C, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_req(6, got); chk(!got, "R4 no request on deassert", got, 0);
    set_pin(0); wait_req(6, got); chk(got, "R4 low edge requests", got, 1);
    accept1;
    set_pin(1); wait_req(8, got); chk(!got, "R4 rising pin is inactive", got, 0);

    // R7 masking
    set_pin(0);
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    set_pin(1); wait_req(6, got); chk(!got, "R7 masked edge", got, 0);
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wait_req(6, got); chk(!got, "R7 masked edge not held", got, 0);
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_req(6, got); chk(!got, "R7 masked level", got, 0);
    rd(0, d); chk(d[14] == 0, "R7 remote-pending untouched", d[14], 0);

    // R10 R11 R12 level
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    wait_req(6, got); chk(got, "R10 level request", got, 1);
    accept1;
    rd(0, d); chk(d[14] == 1, "R10 remote-pending set", d[14], 1);
    wait_req(8, got); chk(!got, "R10 blocked by remote-pending", got, 0);
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    rd(0, d); chk(d[14] == 1, "R12 mask keeps remote-pending", d[14], 1);
    wr(0, low_w(8'h3C, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    eoi(8'h3D);
    rd(0, d); chk(d[14] == 1, "R11 wrong vector kept", d[14], 1);
    eoi(8'h3C); wait_req(6, got);
    chk(got, "R11 reissue after matching eoi", got, 1);

    // R9 R11 random retry runs
    for (int i = 0; i < 10; i++) begin
      int k;
      k = $urandom_range(0, 4);
      for (int j = 0; j < k; j++) begin
        @(negedge clk); send_retry = 1;
        if (j == 1) irq_pin = 0;
        @(negedge clk); send_retry = 0;
        chk(send_req && send_vector == 8'h3C, "R9 random retry hold", send_req, 1);
        irq_pin = 1;
      end
      accept1;
      chk(!send_req, "R10 no double issue", send_req, 0);
      repeat (3) @(negedge clk);
      eoi(8'h3C); wait_req(6, got);
      chk(got, "R11 level repeat", got, 1);
    end
    accept1;
    set_pin(0); repeat (4) @(negedge clk);
    eoi(8'h3C);
    rd(0, d); chk(d[14] == 0, "R11 cleared", d[14], 0);
    wait_req(6, got); chk(!got, "R10 inactive level silent", got, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule